// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This engine drives one open-drain 1-Wire data line that carries an external pull-up. It produces the three basic bus waveforms: a reset with presence detection, a write time slot and a read time slot. A byte transfer is eight consecutive slots, least significant bit first. The engine only ever pulls the line low or lets it go. It models the pin as an active-high "drive low" output plus a sampled line input, and that input passes through a two-flop synchroniser before any decision is made on it.

A parent block starts an operation by raising `cmd_valid` for one cycle with an opcode and, for a write, a data byte. The engine stays busy until the whole bus sequence has finished, and then pulses `done` for one cycle. The presence flag and the received byte remain readable afterwards. All bus timing counts in microseconds. A tick divider, parameterised by the number of clock cycles per microsecond, produces the time base and restarts whenever a command is accepted, so every phase lasts an exact whole number of microseconds.

Top module: `onewire_master`

## Requirements
- R1: After reset, `busy`, `done`, `presence`, `line_drive_low` and `rx_byte` are all 0.
- R2: A reset command (opcode 2'b01) holds `line_drive_low` high for exactly 480 µs (480 × CLK_PER_US cycles) and then releases the line.
- R3: The line is sampled 60 µs after the reset is released. A low level sets `presence` to 1 and a high level sets it to 0. The engine then waits out the rest of a 480 µs reply window, so `busy` lasts 960 µs from acceptance.
- R4: A write command (opcode 2'b10) starts every slot by driving low. A 1 bit is released after 2 µs. A 0 bit is held low for the full 60 µs slot.
- R5: Every slot lasts 60 µs and is followed by a 4 µs recovery gap with the line released, so a byte command is busy for 8 × 64 µs.
- R6: Bytes go out and come in least significant bit first. Bit 0 uses the first slot.
- R7: A read command (opcode 2'b11) drives low for 1 µs per slot and samples the synchronised line 5 µs after the slot starts. A device that holds the line low past 6 µs returns a 0. A device that has released it by 3 µs returns a 1.
- R8: `done` is high for exactly one cycle, in the same cycle that `busy` first reads 0 after an operation.
- R9: `cmd_valid` is ignored while `busy` is high. Opcode 2'b00 is ignored at all times and does not set `busy`.
- R10: `presence` keeps its value until the next reset command, and `rx_byte` keeps its value until the next read command completes.
- R11: `line_drive_low` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 01 reset, 10 write byte, 11 read byte, 00 none |
| cmd_data | input | 8 | Byte to send for a write command |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| presence | output | 1 | A device answered the last reset |
| rx_byte | output | 8 | Byte gathered by the last read command |
| line_drive_low | output | 1 | 1 pulls the bus low, 0 releases it |
| line_in | input | 1 | Level of the bus line (asynchronous) |

## Verification
The bench builds the engine with CLK_PER_US = 4 and keeps the default microsecond timings. This keeps a full 480 µs reset plus its reply window within a few thousand cycles, so every phase can be measured to the exact cycle. At four cycles per microsecond, the 1 µs read pulse, the 2 µs write-one pulse and the two-cycle synchroniser delay stay clearly separated from the 5 µs sample point. The bench can therefore place a device release on either side of that point and see which value is read.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } ow_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_LOW,
    S_RST_REL,
    S_SLOT,
    S_REC
  } ow_state_e;

  // Length in microseconds of the phase a state represents.
  function automatic int phase_len_us(ow_state_e s, int t_rst, int t_slot, int t_rec);
    case (s)
      S_RST_LOW, S_RST_REL: return t_rst;
      S_SLOT:               return t_slot;
      S_REC:                return t_rec;
      default:              return 1;
    endcase
  endfunction

  // Microseconds the line is held low at the start of a slot.
  function automatic int slot_low_us(logic is_read, logic bitv, int t_w1, int t_rd, int t_slot);
    if (is_read) return t_rd;
    return bitv ? t_w1 : t_slot;
  endfunction

endpackage

// File: rtl/onewire_tick.sv
module onewire_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [DW-1:0] cnt;

  assign tick = (cnt == DW'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R5: microsecond ticks are isolated pulses, never back to back
  a_r5_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/onewire_sync.sv
module onewire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];

endmodule

// File: rtl/onewire_core.sv
module onewire_core
  import onewire_pkg::*;
#(
  parameter int T_RST_US  = 480,
  parameter int T_PRES_US = 60,
  parameter int T_SLOT_US = 60,
  parameter int T_W1_US   = 2,
  parameter int T_RD_US   = 1,
  parameter int T_SMP_US  = 5,
  parameter int T_REC_US  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       line_s,
  output logic       tick_clr,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic [7:0] rx_byte,
  output logic       line_drive_low
);
  localparam int CW = $clog2(T_RST_US + 1);

  ow_state_e     st;
  ow_op_e        op_q;
  logic [CW-1:0] us_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;

  // Named internal events
  logic          accept;
  logic          phase_end;
  logic          smp_pres;
  logic          smp_bit;
  logic          last_bit;
  logic          drive_next;
  logic [CW-1:0] cur_len;
  logic [CW-1:0] low_len;

  assign accept    = cmd_valid && (st == S_IDLE) && (ow_op_e'(cmd_op) != OP_NONE);
  assign tick_clr  = accept;
  assign busy      = (st != S_IDLE);
  assign cur_len   = CW'(phase_len_us(st, T_RST_US, T_SLOT_US, T_REC_US));
  assign low_len   = CW'(slot_low_us(op_q == OP_READ, shreg[0], T_W1_US, T_RD_US, T_SLOT_US));
  assign phase_end = tick && (st != S_IDLE) && (us_cnt == cur_len - 1'b1);
  assign smp_pres  = tick && (st == S_RST_REL) && (us_cnt == CW'(T_PRES_US - 1));
  assign smp_bit   = tick && (st == S_SLOT) && (op_q == OP_READ) && (us_cnt == CW'(T_SMP_US - 1));
  assign last_bit  = (bit_idx == 3'd7);
  assign drive_next = (st == S_RST_LOW) || ((st == S_SLOT) && (us_cnt < low_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      op_q           <= OP_NONE;
      us_cnt         <= '0;
      bit_idx        <= '0;
      shreg          <= '0;
      done           <= 1'b0;
      presence       <= 1'b0;
      rx_byte        <= '0;
      line_drive_low <= 1'b0;
    end else begin
      done           <= 1'b0;
      line_drive_low <= drive_next;

      if (phase_end)                     us_cnt <= '0;
      else if (tick && st != S_IDLE)     us_cnt <= us_cnt + 1'b1;

      case (st)
        S_IDLE: begin
          if (accept) begin
            op_q    <= ow_op_e'(cmd_op);
            us_cnt  <= '0;
            bit_idx <= '0;
            case (ow_op_e'(cmd_op))
              OP_RESET: begin
                presence <= 1'b0;
                st       <= S_RST_LOW;
              end
              OP_WRITE: begin
                shreg <= cmd_data;
                st    <= S_SLOT;
              end
              default: begin
                shreg <= '0;
                st    <= S_SLOT;
              end
            endcase
          end
        end
        S_RST_LOW: begin
          if (phase_end) st <= S_RST_REL;
        end
        S_RST_REL: begin
          if (smp_pres) presence <= ~line_s;
          if (phase_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_SLOT: begin
          if (smp_bit) shreg <= {line_s, shreg[7:1]};
          if (phase_end) begin
            st <= S_REC;
            if (op_q == OP_WRITE) shreg <= {1'b0, shreg[7:1]};
          end
        end
        S_REC: begin
          if (phase_end) begin
            if (last_bit) begin
              st   <= S_IDLE;
              done <= 1'b1;
              if (op_q == OP_READ) rx_byte <= shreg;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              st      <= S_SLOT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: busy only ends together with a completion pulse
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11: the bus is released whenever the engine is idle
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_drive_low);

  // R9: an operation only starts from a command strobe
  a_r9_start_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R9: the running operation cannot be changed by new commands
  a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

  // R2: the line is pulled low through the reset low phase
  a_r2_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RST_LOW && us_cnt != '0) |-> line_drive_low);

  // R10: presence is untouched by byte operations
  a_r10_presence_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != OP_RESET) |-> $stable(presence));

endmodule

// File: rtl/onewire_master.sv
module onewire_master #(
  parameter int CLK_PER_US = 50,
  parameter int T_RST_US   = 480,
  parameter int T_PRES_US  = 60,
  parameter int T_SLOT_US  = 60,
  parameter int T_W1_US    = 2,
  parameter int T_RD_US    = 1,
  parameter int T_SMP_US   = 5,
  parameter int T_REC_US   = 4,
  parameter int SYNC_FF    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic [7:0] rx_byte,
  output logic       line_drive_low,
  input  logic       line_in
);
  logic tick;
  logic tick_clr;
  logic line_s;

  onewire_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tick_clr),
    .tick (tick)
  );

  onewire_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (line_s)
  );

  onewire_core #(
    .T_RST_US (T_RST_US),
    .T_PRES_US(T_PRES_US),
    .T_SLOT_US(T_SLOT_US),
    .T_W1_US  (T_W1_US),
    .T_RD_US  (T_RD_US),
    .T_SMP_US (T_SMP_US),
    .T_REC_US (T_REC_US)
  ) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_data      (cmd_data),
    .line_s        (line_s),
    .tick_clr      (tick_clr),
    .busy          (busy),
    .done          (done),
    .presence      (presence),
    .rx_byte       (rx_byte),
    .line_drive_low(line_drive_low)
  );

endmodule

// File: tb/onewire_master_tb_top.sv
`timescale 1ns/1ps
module onewire_master_tb_top;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic       busy, done, presence, drv;
  logic [7:0] rx_byte;
  logic       dev_low = 1'b0;
  logic       line_in;

  always #2 clk = ~clk;

  assign line_in = !(drv || dev_low);

  onewire_master #(.CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .presence(presence),
    .rx_byte(rx_byte), .line_drive_low(drv), .line_in(line_in)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural device on the bus
  bit       slave_present = 1'b0;
  bit       slave_rd      = 1'b0;
  logic [7:0] slave_tx    = 8'h00;
  int       slave_hold    = 7 * CPU;
  int       widths [0:127];
  int       nslots    = 0;
  int       dones     = 0;
  int       fall_cyc  = 0;
  int       hold_until = 0;
  int       pres_s = 0, pres_e = 0;
  int       sidx = 0;
  logic     prev_drv = 1'b0;

  always @(negedge clk) begin
    if (done) dones++;
    if (!busy) sidx = 0;
    if (drv && !prev_drv) begin
      fall_cyc = cyc;
      if (slave_rd) begin
        if (!slave_tx[sidx & 7]) hold_until = cyc + slave_hold;
        sidx++;
      end
    end
    if (!drv && prev_drv) begin
      if (nslots < 128) widths[nslots] = cyc - fall_cyc;
      nslots++;
      if ((cyc - fall_cyc) >= 400 * CPU && slave_present) begin
        pres_s = cyc + 20 * CPU;
        pres_e = cyc + 120 * CPU;
      end
    end
    prev_drv = drv;
    dev_low = (cyc < hold_until) || (cyc >= pres_s && cyc < pres_e);
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] data,
                         output int bcyc, output int done_end);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    bcyc = 0;
    while (busy && bcyc < 20000) begin
      bcyc++;
      @(negedge clk);
    end
    done_end = done;
    @(negedge clk);
    check_eq("R8", "done one cycle only", done, 0);
  endtask

  task automatic t_reset_state();
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "done after reset", done, 0);
    check_eq("R1", "presence after reset", presence, 0);
    check_eq("R1", "rx_byte after reset", rx_byte, 0);
    check_eq("R11", "drive after reset", drv, 0);
  endtask

  task automatic t_bus_reset(bit present);
    int b, d, s0;
    slave_present = present;
    s0 = nslots;
    run_cmd(2'b01, 8'h00, b, d);
    check_eq("R2", "reset low pulses", nslots - s0, 1);
    check_eq("R2", "reset low width", widths[s0], 480 * CPU);
    check_eq("R3", "presence", presence, present);
    check_eq("R3", "reset busy cycles", b, 960 * CPU);
    check_eq("R8", "done as busy falls", d, 1);
    check_eq("R11", "line released after reset", drv, 0);
  endtask

  task automatic t_write(logic [7:0] val);
    int b, d, s0, bad;
    logic [7:0] got;
    s0 = nslots; bad = 0; got = 8'h00;
    run_cmd(2'b10, val, b, d);
    check_eq("R5", "write slot count", nslots - s0, 8);
    for (int i = 0; i < 8; i++) begin
      got[i] = (widths[s0 + i] < 15 * CPU);
      if (widths[s0 + i] != (val[i] ? 2 * CPU : 60 * CPU)) bad++;
    end
    check_eq("R4", "write low widths wrong", bad, 0);
    check_eq("R6", "byte decoded LSB first", got, val);
    check_eq("R6", "first slot carries bit0", widths[s0] < 15 * CPU, val[0]);
    check_eq("R5", "write busy cycles", b, 8 * 64 * CPU);
    check_eq("R8", "write done at end", d, 1);
  endtask

  task automatic t_read(logic [7:0] tx, int hold, logic [7:0] exp);
    int b, d, s0, bad;
    slave_tx = tx; slave_hold = hold; slave_rd = 1'b1;
    s0 = nslots; bad = 0;
    run_cmd(2'b11, 8'h00, b, d);
    slave_rd = 1'b0;
    for (int i = 0; i < 8; i++) if (widths[s0 + i] != 1 * CPU) bad++;
    check_eq("R7", "read low widths wrong", bad, 0);
    check_eq("R7", "read byte value", rx_byte, exp);
    check_eq("R5", "read busy cycles", b, 8 * 64 * CPU);
    check_eq("R8", "read done at end", d, 1);
  endtask

  task automatic t_ignore();
    int s0, d0, b;
    s0 = nslots; d0 = dones;
    slave_present = 1'b1;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b01;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
    repeat (100) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_data = 8'h00;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
    b = 0;
    while (busy && b < 20000) begin b++; @(negedge clk); end
    b = 0;
    repeat (300) begin @(negedge clk); b += busy; end
    check_eq("R9", "no extra slots from busy cmd", nslots - s0, 1);
    check_eq("R9", "busy after ignored cmd", b, 0);
    check_eq("R9", "one completion only", dones - d0, 1);
    cmd_valid = 1'b1; cmd_op = 2'b00;
    @(negedge clk); cmd_valid = 1'b0;
    b = 0;
    repeat (50) begin @(negedge clk); b += busy + drv; end
    check_eq("R9", "opcode 00 activity", b, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_bus_reset(1'b1);
    t_write(8'hA5);
    check_eq("R10", "presence held across write", presence, 1);
    t_read(8'h3C, 7 * CPU, 8'h3C);
    t_read(8'h00, 3 * CPU, 8'hFF);
    t_read(8'h96, 7 * CPU, 8'h96);
    t_bus_reset(1'b0);
    check_eq("R10", "rx_byte held across reset", rx_byte, 8'h96);
    t_write(8'h01);
    check_eq("R10", "rx_byte held across write", rx_byte, 8'h96);
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule